// File: doc/BRIEF.md
# Shadowed Pin-Control Register Bank

This block is a small register bank that controls four open-drain I/O pins. It holds the pullup enables, the pulldown controls, a two-bit reset-delay select and two user bytes. Each of these eight registers has a working copy that drives the outputs and a non-volatile image, modelled here as a register array. It also holds a configuration byte, six plain volatile user bytes and a status byte that samples the pin levels.

A host writes and reads the bank through a flat address/data port. A separate strobe marks the end of each bus transaction. Bit 0 of the configuration byte chooses what a write to a shadowed register does. Either the write changes only the working copy, or the byte is also marked for commit. At the next transaction end, the marked bytes are copied into the image, and a busy flag then stays high for a fixed number of clock cycles.

A system reset reloads every working copy from the image, so the pins come up in their last committed state. A power-on reset puts the image itself back to its factory values.

Top module: `nvx_regbank`

## Requirements
- R1: After power-on reset, the bank reads as follows. F0h=00h, F1h=03h, F2h=F3h=00h, F4h..F7h=01h, F9h=00h and FAh..FFh=00h. The outputs are pu_en=0, pd_en=0, delay_sel=3 and busy=0.
- R2: pu_en[k] equals bit k of register F0h. All 8 bits of F0h are stored and read back.
- R3: Register F4h controls pin 3, F5h pin 2, F6h pin 1 and F7h pin 0. pd_en for a pin is 1 exactly when bit 0 of its register is 0. All 8 bits of these registers are stored and read back.
- R4: Address F8h reads {4'b0000, pin levels}, where the pin levels are sampled one clock earlier. Writes to F8h have no effect.
- R5: delay_sel equals bits 1:0 of register F1h.
- R6: While F9h bit 0 is 1, a write to F0h..F7h changes only the working copy. It marks nothing for commit, so a later system reset restores the old value.
- R7: While F9h bit 0 is 0, a write to F0h..F7h marks that byte. At the next bus_stop with at least one byte marked and busy low, the marked bytes are copied to the image. busy is then high for exactly COMMIT_CYCLES cycles, starting in the cycle after bus_stop. A bus_stop with nothing marked starts no commit.
- R8: A bus_stop while busy is high commits nothing and does not extend busy. Every bus_stop discards all marks.
- R9: A system reset (rst_n low, por_n high) reloads F0h..F7h from the image. It clears F9h, FAh..FFh and busy. The image is kept.
- R10: FAh..FFh are plain read/write bytes. Every other address outside F0h..FFh reads 00h, and writes to it are ignored.
- R11: A shadowed write in the same cycle as bus_stop is included in that commit, with the new data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Synchronous active-low power-on reset; restores the image to factory values |
| rst_n | input | 1 | Synchronous active-low system reset; recalls the image into the working copies |
| wr_en | input | 1 | Write strobe |
| addr | input | 8 | Register address for writes and reads |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for addr (combinational) |
| bus_stop | input | 1 | One-cycle strobe marking the end of a transaction |
| pins_in | input | 4 | Sensed pin levels |
| pu_en | output | 4 | Pullup enable per pin |
| pd_en | output | 4 | Pulldown transistor on, per pin |
| delay_sel | output | 2 | Reset-delay select |
| busy | output | 1 | Non-volatile commit in progress |

## Verification
Two pairs of events can fall in the same cycle. The first is a shadowed write that lands in the same cycle as the transaction-end strobe. The bench provokes it by raising bus_stop together with wr_en on F7h. It then judges the result by the busy window that follows and by the value recalled after a system reset. The second is a transaction end that arrives while a commit is still counting down. Here the behavioural model checks, cycle by cycle, that busy keeps its original length, and a later recall shows that the write made during busy never reached the image.

// File: rtl/nvx_pkg.sv
// Package nvx_pkg
// Shared constants for the shadowed pin-control register bank: the address
// map, the bank sizes and the factory values of the shadowed bytes.
// Assumes an 8-bit address space and an 8-bit data path.
package nvx_pkg;
    localparam int unsigned ADDR_W        = 8;
    localparam int unsigned DATA_W        = 8;
    localparam int unsigned NUM_PINS      = 4;
    localparam int unsigned SHADOW_BYTES  = 8;
    localparam int unsigned USER_BYTES    = 6;
    localparam int unsigned VOLATILE_BIT  = 0;

    localparam logic [ADDR_W-1:0] ADDR_SHADOW = 8'hF0;
    localparam logic [ADDR_W-1:0] ADDR_STATUS = 8'hF8;
    localparam logic [ADDR_W-1:0] ADDR_CONFIG = 8'hF9;
    localparam logic [ADDR_W-1:0] ADDR_USER   = 8'hFA;

    // Factory value of shadowed byte idx (offset from ADDR_SHADOW)
    function automatic logic [DATA_W-1:0] shadow_default(input int unsigned idx);
        if (idx == 1)
            return 8'h03;
        else if (idx >= 4 && idx <= 7)
            return 8'h01;
        else
            return 8'h00;
    endfunction
endpackage

// File: rtl/nvx_commit_timer.sv
// Module nvx_commit_timer
// Counts the non-volatile write window. A start pulse loads COMMIT_CYCLES and
// busy stays high until the count reaches zero.
// Assumes start is raised only while busy is low (the bank guarantees this).
module nvx_commit_timer #(
    parameter int unsigned COMMIT_CYCLES = 2000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    localparam int unsigned CNT_W = $clog2(COMMIT_CYCLES + 1);

    logic [CNT_W-1:0] cnt_q;

    // Load on start, else count down to zero
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (start)
            cnt_q <= CNT_W'(COMMIT_CYCLES);
        else if (cnt_q != '0)
            cnt_q <= cnt_q - CNT_W'(1);
    end

    assign busy = (cnt_q != '0);

    AST_BUSY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(COMMIT_CYCLES)); // R7
    AST_START_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy); // R8
    AST_BUSY_COUNTDOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !start) |=> (cnt_q == $past(cnt_q) - CNT_W'(1))); // R8
endmodule

// File: rtl/nvx_shadow_bank.sv
// Module nvx_shadow_bank
// Holds the working copies and the non-volatile images of the shadowed bytes,
// and the per-byte commit marks. On a commit the marked bytes are copied into
// the image; system reset recalls the image; power-on reset loads factory values.
// Assumes wr_hit is one-hot or zero.
module nvx_shadow_bank #(
    parameter int unsigned N = nvx_pkg::SHADOW_BYTES,
    parameter int unsigned W = nvx_pkg::DATA_W
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              rst_n,
    input  logic [N-1:0]      wr_hit,
    input  logic [W-1:0]      wdata,
    input  logic              nv_mode,
    input  logic              stop,
    input  logic              busy,
    output logic              commit,
    output logic [N-1:0][W-1:0] work
);
    logic [N-1:0][W-1:0] work_q;
    logic [N-1:0][W-1:0] image_q;
    logic [N-1:0]        dirty_q;
    logic [N-1:0]        mask;

    // Marks after this cycle's write: old marks plus a write in NV mode
    assign mask   = dirty_q | (nv_mode ? wr_hit : '0);
    // A commit starts on a transaction end while idle with something marked
    assign commit = stop && !busy && (mask != '0);

    for (genvar i = 0; i < N; i++) begin : g_byte
        localparam logic [W-1:0] DEF = W'(nvx_pkg::shadow_default(i));

        // Working copy: factory value, image recall, or host write
        always_ff @(posedge clk) begin
            if (!por_n)
                work_q[i] <= DEF;
            else if (!rst_n)
                work_q[i] <= image_q[i];
            else if (wr_hit[i])
                work_q[i] <= wdata;
        end

        // Image: factory value, or updated by a commit of a marked byte
        always_ff @(posedge clk) begin
            if (!por_n)
                image_q[i] <= DEF;
            else if (rst_n && commit && mask[i])
                image_q[i] <= wr_hit[i] ? wdata : work_q[i];
        end

        // Commit mark: cleared by reset or by any transaction end
        always_ff @(posedge clk) begin
            if (!por_n || !rst_n)
                dirty_q[i] <= 1'b0;
            else if (stop)
                dirty_q[i] <= 1'b0;
            else
                dirty_q[i] <= mask[i];
        end
    end

    assign work = work_q;

    AST_IMAGE_HOLD: assert property (@(posedge clk) disable iff (!por_n)
        !commit |=> $stable(image_q)); // R6
    AST_MARKS_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        stop |=> (dirty_q == '0)); // R8
endmodule

// File: rtl/nvx_pin_ctrl.sv
// Module nvx_pin_ctrl
// Drives the per-pin pullup and pulldown enables, and registers the sensed
// pin levels for the status byte.
// Assumes pins_in is already synchronous to clk.
module nvx_pin_ctrl #(
    parameter int unsigned P = nvx_pkg::NUM_PINS
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [P-1:0] pu_bits,
    input  logic [P-1:0] pd_bits,
    input  logic [P-1:0] pins_in,
    output logic [P-1:0] pu_en,
    output logic [P-1:0] pd_en,
    output logic [P-1:0] status
);
    for (genvar k = 0; k < P; k++) begin : g_pin
        // Cleared control bit turns the pulldown transistor on
        assign pd_en[k] = ~pd_bits[k];
        assign pu_en[k] = pu_bits[k];
    end

    // Sample pin levels once per clock
    always_ff @(posedge clk) begin
        if (!rst_n)
            status <= '0;
        else
            status <= pins_in;
    end
endmodule

// File: rtl/nvx_regbank.sv
// Module nvx_regbank
// Top of the shadowed pin-control register bank. Decodes host writes, holds the
// configuration byte and the volatile user bytes, and muxes read data. It ties
// the shadowed bytes to the pin controls and to the commit timer.
// Assumes at most one write per cycle and a one-cycle bus_stop strobe.
module nvx_regbank #(
    parameter int unsigned COMMIT_CYCLES = 2000
) (
    input  logic       clk,
    input  logic       por_n,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] addr,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    input  logic       bus_stop,
    input  logic [3:0] pins_in,
    output logic [3:0] pu_en,
    output logic [3:0] pd_en,
    output logic [1:0] delay_sel,
    output logic       busy
);
    import nvx_pkg::*;

    localparam int unsigned N = SHADOW_BYTES;
    localparam int unsigned U = USER_BYTES;
    localparam int unsigned P = NUM_PINS;
    localparam int unsigned W = DATA_W;

    logic [N-1:0]        wr_hit;
    logic [N-1:0][W-1:0] work;
    logic                commit;
    logic [W-1:0]        cfg_q;
    logic [U-1:0][W-1:0] user_q;
    logic [P-1:0]        pd_bits;
    logic [P-1:0]        status;

    for (genvar i = 0; i < N; i++) begin : g_hit
        // Decode a write to shadowed byte i
        assign wr_hit[i] = wr_en && (addr == ADDR_W'(ADDR_SHADOW + i));
    end

    nvx_shadow_bank #(.N(N), .W(W)) u_bank (
        .clk     (clk),
        .por_n   (por_n),
        .rst_n   (rst_n),
        .wr_hit  (wr_hit),
        .wdata   (wdata),
        .nv_mode (!cfg_q[VOLATILE_BIT]),
        .stop    (bus_stop),
        .busy    (busy),
        .commit  (commit),
        .work    (work)
    );

    nvx_commit_timer #(.COMMIT_CYCLES(COMMIT_CYCLES)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (commit),
        .busy  (busy)
    );

    for (genvar k = 0; k < P; k++) begin : g_pdmap
        // Byte at offset 4 controls the highest pin, offset 7 pin 0
        assign pd_bits[k] = work[N-1-k][0];
    end

    nvx_pin_ctrl #(.P(P)) u_pins (
        .clk     (clk),
        .rst_n   (rst_n),
        .pu_bits (work[0][P-1:0]),
        .pd_bits (pd_bits),
        .pins_in (pins_in),
        .pu_en   (pu_en),
        .pd_en   (pd_en),
        .status  (status)
    );

    assign delay_sel = work[1][1:0];

    // Configuration byte: volatile, cleared by either reset
    always_ff @(posedge clk) begin
        if (!por_n || !rst_n)
            cfg_q <= '0;
        else if (wr_en && addr == ADDR_CONFIG)
            cfg_q <= wdata;
    end

    for (genvar u = 0; u < U; u++) begin : g_user
        // Plain volatile user byte u
        always_ff @(posedge clk) begin
            if (!por_n || !rst_n)
                user_q[u] <= '0;
            else if (wr_en && addr == ADDR_W'(ADDR_USER + u))
                user_q[u] <= wdata;
        end
    end

    // Read mux over the whole map; unmapped addresses read zero
    always_comb begin
        rdata = '0;
        for (int i = 0; i < N; i++)
            if (addr == ADDR_W'(ADDR_SHADOW + i)) rdata = work[i];
        if (addr == ADDR_STATUS) rdata = {{(W-P){1'b0}}, status};
        if (addr == ADDR_CONFIG) rdata = cfg_q;
        for (int u = 0; u < U; u++)
            if (addr == ADDR_W'(ADDR_USER + u)) rdata = user_q[u];
    end

    AST_STATUS_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == ADDR_STATUS) |-> (rdata[W-1:P] == '0)); // R4
endmodule

// File: tb/nvx_regbank_bench.sv
`timescale 1ns/1ps
module nvx_regbank_bench;
    localparam int CC = 16;

    logic       clk = 0;
    logic       por_n = 0, rst_n = 0, wr_en = 0, bus_stop = 0;
    logic [7:0] addr = 8'h00, wdata = 8'h00;
    logic [3:0] pins_in = 4'h0;
    logic [7:0] rdata;
    logic [3:0] pu_en, pd_en;
    logic [1:0] delay_sel;
    logic       busy;

    int checks = 0, failures = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    nvx_regbank #(.COMMIT_CYCLES(CC)) u_nvx_regbank (
        .clk(clk), .por_n(por_n), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .bus_stop(bus_stop), .pins_in(pins_in),
        .pu_en(pu_en), .pd_en(pd_en), .delay_sel(delay_sel), .busy(busy));

    // Behavioural reference model
    int m_work[8], m_img[8], m_user[6], m_cfg, m_cnt, m_status;
    bit m_dirty[8];

    function automatic int fdef(int i);
        if (i == 1) return 3;
        if (i >= 4) return 1;
        return 0;
    endfunction

    always @(posedge clk) begin
        bit mask[8];
        bit any, oldbusy;
        int hit;
        if (!por_n) begin
            for (int i = 0; i < 8; i++) begin m_img[i] = fdef(i); m_work[i] = fdef(i); m_dirty[i] = 0; end
            for (int u = 0; u < 6; u++) m_user[u] = 0;
            m_cfg = 0; m_cnt = 0; m_status = 0;
        end else if (!rst_n) begin
            for (int i = 0; i < 8; i++) begin m_work[i] = m_img[i]; m_dirty[i] = 0; end
            for (int u = 0; u < 6; u++) m_user[u] = 0;
            m_cfg = 0; m_cnt = 0; m_status = 0;
        end else begin
            oldbusy = (m_cnt != 0);
            hit = -1;
            if (wr_en && addr >= 8'hF0 && addr <= 8'hF7) hit = int'(addr) - 'hF0;
            any = 0;
            for (int i = 0; i < 8; i++) begin
                mask[i] = m_dirty[i] || (hit == i && (m_cfg & 1) == 0);
                any |= mask[i];
            end
            if (hit >= 0) m_work[hit] = int'(wdata);
            if (wr_en && addr == 8'hF9) m_cfg = int'(wdata);
            if (wr_en && addr >= 8'hFA) m_user[int'(addr) - 'hFA] = int'(wdata);
            if (bus_stop && !oldbusy && any) begin
                for (int i = 0; i < 8; i++) if (mask[i]) m_img[i] = m_work[i];
                m_cnt = CC;
            end else if (oldbusy) m_cnt--;
            for (int i = 0; i < 8; i++) m_dirty[i] = bus_stop ? 0 : mask[i];
            m_status = int'(pins_in);
        end
    end

    function automatic int m_read(int a);
        if (a >= 'hF0 && a <= 'hF7) return m_work[a - 'hF0];
        if (a == 'hF8) return m_status;
        if (a == 'hF9) return m_cfg;
        if (a >= 'hFA && a <= 'hFF) return m_user[a - 'hFA];
        return 0;
    endfunction

    function automatic string rtag(int a);
        if (a == 'hF0) return "R2";
        if (a == 'hF1) return "R5";
        if (a >= 'hF2 && a <= 'hF3) return "R9";
        if (a >= 'hF4 && a <= 'hF7) return "R3";
        if (a == 'hF8) return "R4";
        if (a == 'hF9) return "R6";
        return "R10";
    endfunction

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Compare against the model every clock, after the edge settles
    always @(posedge clk) begin
        #1;
        if (por_n && rst_n && !done) begin
            int pd, pu;
            pd = 0;
            for (int k = 0; k < 4; k++) if ((m_work[7-k] & 1) == 0) pd |= (1 << k);
            pu = m_work[0] & 'hF;
            chk("R2 pu_en", int'(pu_en), pu);
            chk("R3 pd_en", int'(pd_en), pd);
            chk("R5 delay_sel", int'(delay_sel), m_work[1] & 3);
            chk("R7 busy", int'(busy), int'(m_cnt != 0));
            chk(rtag(int'(addr)), int'(rdata), m_read(int'(addr)));
        end
    end

    task automatic wr(input logic [7:0] a, input logic [7:0] d, input bit stp);
        @(negedge clk); wr_en = 1; addr = a; wdata = d; bus_stop = stp;
        @(negedge clk); wr_en = 0; bus_stop = 0;
    endtask
    task automatic stop_only();
        @(negedge clk); bus_stop = 1;
        @(negedge clk); bus_stop = 0;
    endtask
    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask
    task automatic rd_chk(input logic [7:0] a, int exp, string tag);
        @(negedge clk); addr = a; #0.5;
        chk(tag, int'(rdata), exp);
    endtask
    task automatic sys_reset();
        @(negedge clk); rst_n = 0;
        @(negedge clk); rst_n = 1;
    endtask

    initial begin
        #(200000 * 5);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        idle(3);
        por_n = 1; rst_n = 1;
        idle(1);
        // R1: factory reset state
        for (int a = 'hF0; a <= 'hFF; a++)
            if (a != 'hF8) rd_chk(8'(a), (a == 'hF1) ? 3 : (a >= 'hF4 && a <= 'hF7) ? 1 : 0, "R1");
        chk("R1 busy", int'(busy), 0);
        chk("R1 pd_en", int'(pd_en), 0);
        chk("R1 delay_sel", int'(delay_sel), 3);

        // R2/R7: NV write, commit at stop
        wr(8'hF0, 8'hA5, 0);
        rd_chk(8'hF0, 8'hA5, "R2");
        chk("R2 pu_en", int'(pu_en), 5);
        stop_only();
        chk("R7 busy after stop", int'(busy), 1);
        // R8: write and stop while busy are not committed
        wr(8'hF4, 8'h00, 0);
        stop_only();
        idle(CC + 2);
        chk("R8 busy ended", int'(busy), 0);
        sys_reset();
        rd_chk(8'hF0, 8'hA5, "R9");
        rd_chk(8'hF4, 8'h01, "R8");

        // R6: volatile mode
        wr(8'hF9, 8'h01, 0);
        wr(8'hF1, 8'h02, 0);
        wr(8'hF5, 8'hFE, 0);
        stop_only();
        chk("R6 no busy", int'(busy), 0);
        chk("R5 delay_sel", int'(delay_sel), 2);
        chk("R3 pd_en", int'(pd_en), 4'b0100);
        rd_chk(8'hF5, 8'hFE, "R3");
        sys_reset();
        rd_chk(8'hF1, 8'h03, "R6");
        rd_chk(8'hF5, 8'h01, "R6");
        rd_chk(8'hF9, 8'h00, "R9");

        // R11: write in the stop cycle is committed
        wr(8'hF7, 8'h80, 1);
        chk("R11 busy", int'(busy), 1);
        idle(CC + 2);
        sys_reset();
        rd_chk(8'hF7, 8'h80, "R11");
        chk("R11 pd_en", int'(pd_en), 4'b0001);

        // R7: stop with nothing marked
        stop_only();
        chk("R7 idle stop", int'(busy), 0);

        // R4: status sampling, write ignored
        pins_in = 4'hA;
        idle(2);
        rd_chk(8'hF8, 8'h0A, "R4");
        wr(8'hF8, 8'hFF, 0);
        rd_chk(8'hF8, 8'h0A, "R4");

        // R10: user bytes and unmapped addresses
        wr(8'hFC, 8'h5A, 0);
        rd_chk(8'hFC, 8'h5A, "R10");
        wr(8'h20, 8'h77, 0);
        rd_chk(8'h20, 8'h00, "R10");
        wr(8'hFA, 8'h11, 0);
        sys_reset();
        rd_chk(8'hFA, 8'h00, "R9");

        idle(2);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule